// File: doc/BRIEF.md
# USB OTG Interrupt Status and Mask Unit

This block gathers the event pulses of a USB OTG controller wrapper into one 32-bit sticky source word and drives a single interrupt line to the processor. The events are per-endpoint transmit completions, per-endpoint receive completions, eight core bus events and a VBUS-drive change. Software reaches the unit through a plain 32-bit register port addressed by word. Set and clear aliases let software raise or acknowledge any source bit, and enable or disable any mask bit, without a read-modify-write sequence.

The interrupt line is a one-cycle pulse. After it fires it stays off, even while unmasked sources remain pending. It comes back only when software writes the end-of-interrupt word. The usual service sequence is: read the masked view, clear those bits through the clear alias, then write end-of-interrupt. Anything still pending, or anything that arrives later, then raises a fresh pulse. A soft-reset bit in the control word clears all source and mask state.

Top module: `usb_irq_hub`

## Requirements
- R1: After the synchronous reset, the source and mask words read 0, `irq` is low, and the output is armed.
- R2: A one-cycle event pulse sets its source bit, and the bit stays set until it is cleared. Transmit event i (0..4) maps to bit i. Receive event j (0..3, for endpoints 1..4) maps to bit 9+j. Core event k (0..7) maps to bit 16+k. The VBUS-drive change maps to bit 24.
- R3: Writing word 9 (source-set) forces every source bit that is written as 1 to 1.
- R4: Writing word 10 (source-clear) clears every source bit that is written as 1. An event pulse in the same cycle wins, so that bit stays set.
- R5: Writing word 12 (mask-set) sets mask bits and writing word 13 (mask-clear) clears them. The mask reads at word 11, and writes to word 11 have no effect.
- R6: Reading word 14 returns the source word ANDed with the mask word.
- R7: Only bits 0-4, 9-12 and 16-24 exist, so the valid field is 0x01FF1E1F. Every other bit reads 0, and writing 1 to it has no effect.
- R8: While the output is armed and the masked source is nonzero, `irq` pulses high for exactly one cycle, one cycle later. The output then disarms and stays low.
- R9: Any write to word 15 (end-of-interrupt) re-arms the output. If the masked source is nonzero, `irq` then pulses in the next cycle.
- R10: Writing word 1 (control) with bit 0 set clears the source and mask words, re-arms the output and holds `irq` low. Writing it with bit 0 clear has no effect. Word 1 reads 0.
- R11: Read data appears one cycle after `rd_en`. It is 0 for unmapped words, for the alias words and in cycles without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| tx_ev | input | 5 | Transmit endpoint event pulses (endpoints 0..4) |
| rx_ev | input | 4 | Receive endpoint event pulses (endpoints 1..4) |
| core_ev | input | 8 | Core bus event pulses |
| vbus_ev | input | 1 | VBUS-drive change event pulse |
| irq | output | 1 | Interrupt pulse, held off until end-of-interrupt |

## Verification
A write, an event pulse or a soft reset changes the source and mask words at the next edge, so a read issued in the following cycle sees the change. Read data comes one edge after the read strobe. The interrupt pulse comes two edges after the event or write that makes the masked source nonzero, and one edge after an end-of-interrupt write when sources are already pending. The bench drives inputs on falling edges and updates a behavioural model on each rising edge. Every falling edge it compares `irq` and `rdata` against that model, and directed reads compare against hand-computed words at exactly these latencies.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;
  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL     = 4'd1,
    A_SRC      = 4'd8,
    A_SRC_SET  = 4'd9,
    A_SRC_CLR  = 4'd10,
    A_MASK     = 4'd11,
    A_MASK_SET = 4'd12,
    A_MASK_CLR = 4'd13,
    A_MASKED   = 4'd14,
    A_EOI      = 4'd15
  } reg_word_e;

  function automatic logic [31:0] field_bits(input int lsb, input int n);
    logic [31:0] v;
    v = '0;
    for (int i = 0; i < n; i++) v[lsb+i] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/irq_event_pack.sv
module irq_event_pack #(
  parameter int DW       = 32,
  parameter int TX_N     = 5,
  parameter int TX_LSB   = 0,
  parameter int RX_N     = 4,
  parameter int RX_LSB   = 9,
  parameter int CORE_N   = 8,
  parameter int CORE_LSB = 16
) (
  input  logic [TX_N-1:0]   tx_ev,
  input  logic [RX_N-1:0]   rx_ev,
  input  logic [CORE_N-1:0] core_ev,
  input  logic              vbus_ev,
  output logic [DW-1:0]     ev_vec
);
  localparam int VBUS_BIT = CORE_LSB + CORE_N;

  always_comb begin
    ev_vec = '0;
    ev_vec[TX_LSB +: TX_N]     = tx_ev;
    ev_vec[RX_LSB +: RX_N]     = rx_ev;
    ev_vec[CORE_LSB +: CORE_N] = core_ev;
    ev_vec[VBUS_BIT]           = vbus_ev;
  end
endmodule

// File: rtl/irq_bitreg.sv
module irq_bitreg #(
  parameter int          DW    = 32,
  parameter logic [31:0] VALID = 32'hFFFF_FFFF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_all,
  input  logic [DW-1:0] set_v,
  input  logic [DW-1:0] clr_v,
  output logic [DW-1:0] q
);
  // one flop per existing bit; absent positions are tied to zero
  for (genvar i = 0; i < DW; i++) begin : g_bit
    if (VALID[i]) begin : g_ff
      always_ff @(posedge clk) begin
        if (rst || clr_all) q[i] <= 1'b0;
        else                q[i] <= (q[i] & ~clr_v[i]) | set_v[i];
      end
    end else begin : g_tie
      assign q[i] = 1'b0;
    end
  end
endmodule

// File: rtl/irq_eoi_gate.sv
module irq_eoi_gate (
  input  logic clk,
  input  logic rst,
  input  logic soft_clr,
  input  logic eoi_wr,
  input  logic pending,
  output logic irq
);
  logic armed;
  logic fire;

  assign fire = armed && pending;

  always_ff @(posedge clk) begin
    if (rst || soft_clr) begin
      armed <= 1'b1;
      irq   <= 1'b0;
    end else begin
      irq <= fire;
      if (eoi_wr)    armed <= 1'b1;
      else if (fire) armed <= 1'b0;
    end
  end
endmodule

// File: rtl/usb_irq_hub.sv
module usb_irq_hub
  import usb_irq_pkg::*;
#(
  parameter int DW       = 32,
  parameter int TX_N     = 5,
  parameter int TX_LSB   = 0,
  parameter int RX_N     = 4,
  parameter int RX_LSB   = 9,
  parameter int CORE_N   = 8,
  parameter int CORE_LSB = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  input  logic [TX_N-1:0]   tx_ev,
  input  logic [RX_N-1:0]   rx_ev,
  input  logic [CORE_N-1:0] core_ev,
  input  logic              vbus_ev,
  output logic              irq
);
  localparam logic [31:0] VALID = field_bits(TX_LSB, TX_N)
                                | field_bits(RX_LSB, RX_N)
                                | field_bits(CORE_LSB, CORE_N + 1);

  logic [DW-1:0] ev_vec;
  logic [DW-1:0] src_q, mask_q, masked;
  logic [DW-1:0] src_set, src_clr, msk_set, msk_clr;
  logic          soft_wr, eoi_wr;

  irq_event_pack #(
    .DW(DW), .TX_N(TX_N), .TX_LSB(TX_LSB), .RX_N(RX_N), .RX_LSB(RX_LSB),
    .CORE_N(CORE_N), .CORE_LSB(CORE_LSB)
  ) u_pack (
    .tx_ev(tx_ev), .rx_ev(rx_ev), .core_ev(core_ev), .vbus_ev(vbus_ev),
    .ev_vec(ev_vec)
  );

  always_comb begin
    soft_wr = wr_en && (addr == A_CTRL) && wdata[0];
    eoi_wr  = wr_en && (addr == A_EOI);
    src_set = ev_vec | ((wr_en && addr == A_SRC_SET) ? wdata : '0);
    src_clr = (wr_en && addr == A_SRC_CLR) ? wdata : '0;
    msk_set = (wr_en && addr == A_MASK_SET) ? wdata : '0;
    msk_clr = (wr_en && addr == A_MASK_CLR) ? wdata : '0;
    masked  = src_q & mask_q;
  end

  irq_bitreg #(.DW(DW), .VALID(VALID)) u_src (
    .clk(clk), .rst(rst), .clr_all(soft_wr),
    .set_v(src_set), .clr_v(src_clr), .q(src_q)
  );

  irq_bitreg #(.DW(DW), .VALID(VALID)) u_mask (
    .clk(clk), .rst(rst), .clr_all(soft_wr),
    .set_v(msk_set), .clr_v(msk_clr), .q(mask_q)
  );

  irq_eoi_gate u_gate (
    .clk(clk), .rst(rst), .soft_clr(soft_wr), .eoi_wr(eoi_wr),
    .pending(|masked), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (rst || !rd_en) begin
      rdata <= '0;
    end else begin
      case (addr)
        A_SRC:    rdata <= src_q;
        A_MASK:   rdata <= mask_q;
        A_MASKED: rdata <= masked;
        default:  rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/usb_irq_hub_chk.sv
module usb_irq_hub_chk #(
  parameter int          DW    = 32,
  parameter logic [31:0] VALID = 32'h01FF_1E1F
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic          rd_en,
  input logic [3:0]    addr,
  input logic [DW-1:0] wdata,
  input logic [DW-1:0] rdata,
  input logic          irq,
  input logic [DW-1:0] src_q,
  input logic [DW-1:0] mask_q,
  input logic [DW-1:0] ev_vec
);
  logic soft_wr, eoi_wr, eoi_prev;
  assign soft_wr = wr_en && addr == 4'd1 && wdata[0];
  assign eoi_wr  = wr_en && addr == 4'd15;

  always_ff @(posedge clk) begin
    if (rst) eoi_prev <= 1'b0;
    else     eoi_prev <= eoi_wr;
  end

  // R8: a pulse lasts one cycle unless end-of-interrupt re-armed it
  p_single_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    (irq && !eoi_prev) |=> !irq);

  // R8: a pulse needs an unmasked pending source in the cycle before
  p_irq_cause_r8: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past((src_q & mask_q) != '0));

  // R2: every event pulse leaves its source bit set
  p_sticky_src_r2: assert property (@(posedge clk) disable iff (rst)
    !soft_wr |=> (($past(ev_vec) & ~src_q) == '0));

  // R10: soft reset empties source and mask
  p_soft_reset_r10: assert property (@(posedge clk) disable iff (rst)
    soft_wr |=> (src_q == '0 && mask_q == '0 && !irq));

  // R6: the masked view equals source AND mask at the read cycle
  p_masked_read_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == 4'd14) |=> rdata == ($past(src_q) & $past(mask_q)));

  // R7: absent bit positions never read as 1
  p_unused_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (rdata & ~VALID) == '0);
endmodule

bind usb_irq_hub usb_irq_hub_chk #(.DW(DW), .VALID(VALID)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .irq(irq), .src_q(src_q),
  .mask_q(mask_q), .ev_vec(ev_vec)
);

// File: tb/usb_irq_hub_bench.sv
`timescale 1ns/1ps
module usb_irq_hub_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [4:0]  tx_ev = '0;
  logic [3:0]  rx_ev = '0;
  logic [7:0]  core_ev = '0;
  logic        vbus_ev = 1'b0;
  logic        irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  usb_irq_hub u_usb_irq_hub (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .tx_ev(tx_ev), .rx_ev(rx_ev),
    .core_ev(core_ev), .vbus_ev(vbus_ev), .irq(irq)
  );

  // behavioural reference model
  localparam logic [31:0] LIVE = 32'h01FF_1E1F;
  logic [31:0] m_src = 0, m_mask = 0, m_rd = 0;
  bit m_armed = 1, m_irq = 0;

  always @(posedge clk) begin
    logic [31:0] ev, s0, k0;
    bit a0, go;
    s0 = m_src; k0 = m_mask; a0 = m_armed;
    ev = {7'd0, vbus_ev, core_ev, 3'd0, rx_ev, 4'd0, tx_ev};
    if (rst) begin
      m_src = 0; m_mask = 0; m_armed = 1; m_irq = 0; m_rd = 0;
    end else begin
      m_rd = 0;
      if (rd_en) begin
        if (addr == 8)       m_rd = s0;
        else if (addr == 11) m_rd = k0;
        else if (addr == 14) m_rd = s0 & k0;
      end
      if (wr_en && addr == 1 && wdata[0]) begin
        m_src = 0; m_mask = 0; m_armed = 1; m_irq = 0;
      end else begin
        m_src = s0;
        if (wr_en && addr == 10) m_src = m_src & ~wdata;
        if (wr_en && addr == 9)  m_src = m_src | wdata;
        m_src = (m_src | ev) & LIVE;
        m_mask = k0;
        if (wr_en && addr == 12) m_mask = (m_mask | wdata) & LIVE;
        if (wr_en && addr == 13) m_mask = m_mask & ~wdata;
        go = a0 && ((s0 & k0) != 0);
        m_irq = go;
        if (wr_en && addr == 15) m_armed = 1;
        else if (go)             m_armed = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      n_chk++;
      if (irq !== m_irq) begin
        n_fail++;
        $display("FAIL R8 irq per-cycle compare: actual %0b expected %0b at %0t", irq, m_irq, $time);
      end
      n_chk++;
      if (rdata !== m_rd) begin
        n_fail++;
        $display("FAIL R11 rdata per-cycle compare: actual %h expected %h at %0t", rdata, m_rd, $time);
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0; wdata = 0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string req);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0;
    chk(req, rdata, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired: actual running expected finished");
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    chk("R1 irq after reset", {31'd0, irq}, 0);
    rd(8, 32'h0, "R1 source after reset");
    rd(11, 32'h0, "R1 mask after reset");

    wr(12, 32'hFFFF_FFFF);
    rd(11, 32'h01FF_1E1F, "R5 R7 mask-set, live bits only");

    @(negedge clk); tx_ev = 5'b00100;
    @(negedge clk); tx_ev = 0;
    @(negedge clk); chk("R8 irq pulse", {31'd0, irq}, 1);
    @(negedge clk); chk("R8 irq one cycle", {31'd0, irq}, 0);

    @(negedge clk); rx_ev = 4'b0001;
    @(negedge clk); rx_ev = 0;
    rd(14, 32'h0000_0204, "R2 R6 masked view");
    chk("R8 held off while disarmed", {31'd0, irq}, 0);

    wr(10, 32'h4);
    rd(8, 32'h0000_0200, "R4 source-clear");

    wr(15, 32'h0);
    @(negedge clk); chk("R9 EOI re-fires on pending", {31'd0, irq}, 1);

    wr(10, 32'hFFFF_FFFF);
    rd(8, 32'h0, "R4 clear all");
    wr(15, 32'hDEAD_BEEF);
    repeat (2) @(negedge clk);
    chk("R9 no pulse with nothing pending", {31'd0, irq}, 0);

    wr(9, 32'h8100_0000);
    rd(8, 32'h0100_0000, "R3 R7 source-set");

    @(negedge clk); wr_en = 1; addr = 10; wdata = 32'h0100_0000; vbus_ev = 1;
    @(negedge clk); wr_en = 0; wdata = 0; vbus_ev = 0;
    rd(8, 32'h0100_0000, "R4 event beats clear");

    @(negedge clk); core_ev = 8'h81;
    @(negedge clk); core_ev = 0;
    rd(8, 32'h0181_0000, "R2 core events");

    wr(11, 32'h0);
    rd(11, 32'h01FF_1E1F, "R5 mask word write ignored");
    wr(13, 32'h0100_0000);
    rd(14, 32'h0081_0000, "R5 R6 mask-clear then masked view");

    wr(1, 32'h2);
    rd(8, 32'h0181_0000, "R10 control bit0 clear no effect");
    rd(1, 32'h0, "R10 control reads zero");
    rd(3, 32'h0, "R11 unmapped word");
    rd(9, 32'h0, "R11 alias word reads zero");

    wr(1, 32'h1);
    rd(8, 32'h0, "R10 soft reset source");
    rd(11, 32'h0, "R10 soft reset mask");

    // random traffic, judged by the per-cycle model compare (R2 R3 R4 R5 R8 R9)
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      wr_en   = ($urandom % 3) == 0;
      rd_en   = ($urandom % 2) == 0;
      addr    = 4'($urandom);
      wdata   = $urandom;
      if (addr == 1 && ($urandom % 8) != 0) wdata[0] = 0;
      tx_ev   = (($urandom % 4) == 0) ? 5'($urandom) : 5'd0;
      rx_ev   = (($urandom % 4) == 0) ? 4'($urandom) : 4'd0;
      core_ev = (($urandom % 6) == 0) ? 8'($urandom) : 8'd0;
      vbus_ev = ($urandom % 10) == 0;
    end
    @(negedge clk);
    wr_en = 0; rd_en = 0; tx_ev = 0; rx_ev = 0; core_ev = 0; vbus_ev = 0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule